// File: doc/BRIEF.md
# Dual-Channel High/Low Count Pulse-Width Modulator

This block drives two independent pulse-width modulated outputs. Each waveform is described by two 16-bit counts: one sets how many prescaled ticks the output stays low, the other how many it stays high. A period is always a low phase followed by a high phase. Software programs the block through a small word-addressed register bank with write and read strobes, an address and a 32-bit data bus. There is one count register per channel and one control word that both channels share.

Each channel picks one of four timing sources. The sources are single-cycle tick strobes in the system clock domain. The picked stream is divided by a 7-bit prescaler and can be frozen with a gate bit. A separate enable bit starts the output and stops it at once. The hardware has no polarity control: an inverted waveform is obtained by swapping the two counts.

Top module: `pwm_hilo_dual`

## Requirements
- R1: While reset is asserted, and after it is released, both outputs are low and every register reads back zero.
- R2: Registers sit at byte offsets 0x0 (channel A counts), 0x4 (channel B counts) and 0x8 (shared control). A read strobe returns the addressed register's last written value on `bus_rdata` one cycle later. Any other address reads as zero, and writes to it are ignored.
- R3: In a count register, bits 31:16 hold the high count and bits 15:0 hold the low count. In the control word, bit 0 enables channel A and bit 1 enables channel B. Bits 5:4 select A's source and bits 7:6 select B's. Bits 14:8 hold A's prescaler and bits 22:16 hold B's. Bit 15 gates A and bit 23 gates B.
- R4: While enabled, the output is low for max(low,1) prescaled ticks and then high for `high` prescaled ticks, and this repeats.
- R5: A high count of zero keeps the output low for as long as the channel is enabled.
- R6: With the high count at 0xFFFF and the low count at 0, the output is low for exactly one tick and high for the rest of the period.
- R7: Writing a control word with a channel's enable bit cleared makes that output low in the next cycle, even in the middle of a period.
- R8: The prescaler issues one tick for every (field+1) strobes of the selected source, where source n is `src_tick[n]`.
- R9: With the gate bit cleared and the enable bit set, the channel's counters stop and its output keeps its level.
- R10: Setting the enable bit starts the channel at the beginning of its low phase. Counts are taken from the count register at each period boundary, so a write made mid-period takes effect from the next period.
- R11: Writing one channel's count register does not change the other channel's count readback or waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| src_tick | input | 4 | Four timing-source tick strobes |
| pwm_out | output | 2 | Outputs, bit 0 channel A, bit 1 channel B |

## Verification
The hardest condition to reach is a count write that lands in the middle of a running period. Its effect must be deferred to the next boundary, and a wrong design shows the error only one period later. The bench enables a channel with every-cycle ticks, rewrites its counts one cycle into the low phase, and counts the high cycles of that first period. The gate freeze and the one-tick low pulse at maximum high count are reached the same way, by steering deterministic tick streams. A behavioural model is compared with both outputs on every clock, while random source ticks run on both channels.

// File: rtl/pwm_hilo_pkg.sv
package pwm_hilo_pkg;
  localparam int CH_N     = 2;
  localparam int DATA_W   = 32;
  localparam int CNT_W    = 16;
  localparam int DIV_W    = 7;
  localparam int SEL_W    = 2;
  localparam int SRC_N    = 1 << SEL_W;
  localparam int SEL_LSB  = 4;
  localparam int DIV_LSB  = 8;
  localparam int GATE_LSB = 15;
  localparam int LANE_W   = 8;

  typedef struct packed {
    logic             en;
    logic             gate;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_hilo_regs.sv
module pwm_hilo_regs
  import pwm_hilo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  output chan_cfg_t [CH_N-1:0]        cfg,
  output logic [CH_N-1:0][CNT_W-1:0]  lo_cnt,
  output logic [CH_N-1:0][CNT_W-1:0]  hi_cnt
);
  localparam int CTRL_ADDR = 4 * CH_N;

  logic [CH_N-1:0][DATA_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0]           ctrl_q, ctrl_d;
  logic [DATA_W-1:0]           rdata_q, rdata_d;
  logic [DATA_W-1:0]           rd_mux;

  always_comb begin
    cnt_d  = cnt_q;
    ctrl_d = ctrl_q;
    rd_mux = '0;
    for (int c = 0; c < CH_N; c++) begin
      if (bus_wr && (bus_addr == ADDR_W'(4 * c))) cnt_d[c] = bus_wdata;
      if (bus_addr == ADDR_W'(4 * c)) rd_mux = cnt_q[c];
    end
    if (bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR))) ctrl_d = bus_wdata;
    if (bus_addr == ADDR_W'(CTRL_ADDR)) rd_mux = ctrl_q;
    rdata_d = bus_rd ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ctrl_q  <= '0;
      rdata_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      ctrl_q  <= ctrl_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

  for (genvar c = 0; c < CH_N; c++) begin : g_field
    assign cfg[c].en   = ctrl_q[c];
    assign cfg[c].sel  = ctrl_q[SEL_LSB + SEL_W * c +: SEL_W];
    assign cfg[c].div  = ctrl_q[DIV_LSB + LANE_W * c +: DIV_W];
    assign cfg[c].gate = ctrl_q[GATE_LSB + LANE_W * c];
    assign lo_cnt[c]   = cnt_q[c][CNT_W-1:0];
    assign hi_cnt[c]   = cnt_q[c][2*CNT_W-1:CNT_W];
  end
endmodule

// File: rtl/pwm_hilo_presc.sv
module pwm_hilo_presc
  import pwm_hilo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             gate,
  input  logic [SRC_N-1:0] src_tick,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pc_q, pc_d;
  logic             adv;
  logic             wrap;

  assign adv  = run && gate && src_tick[sel];
  assign wrap = (pc_q == div);
  assign tick = adv && wrap;

  always_comb begin
    pc_d = pc_q;
    if (!run)     pc_d = '0;
    else if (adv) pc_d = wrap ? '0 : pc_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/pwm_hilo_phase.sv
module pwm_hilo_phase
  import pwm_hilo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] lo_in,
  input  logic [CNT_W-1:0] hi_in,
  output logic             out
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             hi_ph_q, hi_ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lo_q, lo_d;
  logic [CNT_W-1:0] hi_q, hi_d;
  logic [CNT_W-1:0] low_last;

  assign low_last = (lo_q == '0) ? '0 : lo_q - ONE;

  always_comb begin
    hi_ph_d = hi_ph_q;
    cnt_d   = cnt_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    if (!en) begin
      hi_ph_d = 1'b0;
      cnt_d   = '0;
      lo_d    = lo_in;
      hi_d    = hi_in;
    end else if (tick) begin
      if (!hi_ph_q) begin
        if (cnt_q == low_last) begin
          cnt_d = '0;
          if (hi_q == '0) begin
            lo_d = lo_in;
            hi_d = hi_in;
          end else begin
            hi_ph_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (cnt_q == hi_q - ONE) begin
          hi_ph_d = 1'b0;
          cnt_d   = '0;
          lo_d    = lo_in;
          hi_d    = hi_in;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_ph_q <= 1'b0;
      cnt_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      hi_ph_q <= hi_ph_d;
      cnt_q   <= cnt_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
    end
  end

  assign out = en && hi_ph_q;
endmodule

// File: rtl/pwm_hilo_dual.sv
module pwm_hilo_dual
  import pwm_hilo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [SRC_N-1:0]  src_tick,
  output logic [CH_N-1:0]   pwm_out
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  chan_cfg_t [CH_N-1:0]        cfg;
  logic [CH_N-1:0][CNT_W-1:0]  lo_cnt;
  logic [CH_N-1:0][CNT_W-1:0]  hi_cnt;
  logic [CH_N-1:0]             ch_tick;

  pwm_hilo_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg       (cfg),
    .lo_cnt    (lo_cnt),
    .hi_cnt    (hi_cnt)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    pwm_hilo_presc u_presc (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .run      (cfg[c].en),
      .gate     (cfg[c].gate),
      .src_tick (src_tick),
      .sel      (cfg[c].sel),
      .div      (cfg[c].div),
      .tick     (ch_tick[c])
    );

    pwm_hilo_phase u_phase (
      .clk   (clk),
      .rst_n (rst_int_n),
      .en    (cfg[c].en),
      .tick  (ch_tick[c]),
      .lo_in (lo_cnt[c]),
      .hi_in (hi_cnt[c]),
      .out   (pwm_out[c])
    );
  end
endmodule

// File: rtl/pwm_hilo_chk.sv
module pwm_hilo_chk
  import pwm_hilo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [CH_N-1:0]      pwm_out,
  input chan_cfg_t [CH_N-1:0] cfg
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(4 * CH_N);

  always @(negedge clk) begin
    if (!rst_n) a_r1_reset_low: assert (pwm_out == '0);
  end

  a_r7_stop_a: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CTRL_A && !bus_wdata[0]) |=> !pwm_out[0]);

  a_r7_stop_b: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CTRL_A && !bus_wdata[1]) |=> !pwm_out[1]);

  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr > CTRL_A) |=> (bus_rdata == '0));

  a_r9_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[0].en && !cfg[0].gate && !(bus_wr && bus_addr == CTRL_A))
      |=> $stable(pwm_out[0]));
endmodule

bind pwm_hilo_dual pwm_hilo_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pwm_out   (pwm_out),
  .cfg       (cfg)
);

// File: tb/pwm_hilo_dual_test.sv
module pwm_hilo_dual_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_tick = '0;
  logic [1:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  pwm_hilo_dual uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_tick(src_tick), .pwm_out(pwm_out)
  );

  // source strobes: 0 every cycle, 1 every third, 2 random, 3 every fifth
  always @(negedge clk) begin
    cyc <= cyc + 1;
    src_tick[0] <= 1'b1;
    src_tick[1] <= (cyc % 3) == 0;
    src_tick[2] <= 1'($urandom_range(0, 1));
    src_tick[3] <= (cyc % 5) == 0;
  end

  // behavioural reference model
  logic [31:0] m_ctrl;
  logic [31:0] m_cnt [2];
  int m_pc [2];
  int m_c  [2];
  int m_lo [2];
  int m_hi [2];
  bit m_ph [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0;
      for (int ch = 0; ch < 2; ch++) begin
        m_cnt[ch] = 0; m_pc[ch] = 0; m_c[ch] = 0;
        m_lo[ch] = 0; m_hi[ch] = 0; m_ph[ch] = 0;
      end
    end else begin
      for (int ch = 0; ch < 2; ch++) begin
        bit en, gt, tk;
        int sl, dv, lowlen;
        en = m_ctrl[ch];
        gt = m_ctrl[15 + 8 * ch];
        sl = int'((m_ctrl >> (4 + 2 * ch)) & 32'h3);
        dv = int'((m_ctrl >> (8 + 8 * ch)) & 32'h7f);
        if (!en) begin
          m_pc[ch] = 0; m_c[ch] = 0; m_ph[ch] = 0;
          m_lo[ch] = int'(m_cnt[ch][15:0]);
          m_hi[ch] = int'(m_cnt[ch][31:16]);
        end else begin
          tk = 0;
          if (gt && src_tick[sl]) begin
            if (m_pc[ch] == dv) begin tk = 1; m_pc[ch] = 0; end
            else m_pc[ch] = (m_pc[ch] + 1) % 128;
          end
          if (tk) begin
            if (!m_ph[ch]) begin
              lowlen = (m_lo[ch] == 0) ? 1 : m_lo[ch];
              if (m_c[ch] + 1 >= lowlen) begin
                m_c[ch] = 0;
                if (m_hi[ch] == 0) begin
                  m_lo[ch] = int'(m_cnt[ch][15:0]);
                  m_hi[ch] = int'(m_cnt[ch][31:16]);
                end else m_ph[ch] = 1;
              end else m_c[ch] = m_c[ch] + 1;
            end else begin
              if (m_c[ch] + 1 >= m_hi[ch]) begin
                m_ph[ch] = 0; m_c[ch] = 0;
                m_lo[ch] = int'(m_cnt[ch][15:0]);
                m_hi[ch] = int'(m_cnt[ch][31:16]);
              end else m_c[ch] = m_c[ch] + 1;
            end
          end
        end
      end
      if (bus_wr) begin
        if (bus_addr == 4'h0) m_cnt[0] = bus_wdata;
        if (bus_addr == 4'h4) m_cnt[1] = bus_wdata;
        if (bus_addr == 4'h8) m_ctrl = bus_wdata;
      end
    end
  end

  // R4 R3: per-cycle comparison of both outputs with the model
  always @(negedge clk) begin
    if (!finished) begin
      for (int ch = 0; ch < 2; ch++) begin
        bit exp;
        exp = m_ctrl[ch] && m_ph[ch];
        checks++;
        if (pwm_out[ch] !== exp) begin
          errors++;
          $display("FAIL R4 ch%0d cycle %0d: pwm_out=%b expected %b", ch, cyc, pwm_out[ch], exp);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check(bus_rdata === exp, req, bus_rdata, exp);
  endtask

  task automatic summary;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int nh;
    logic lvl;
    repeat (3) @(negedge clk);
    check(pwm_out === 2'b00, "R1 out in reset", 32'(pwm_out), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(pwm_out === 2'b00, "R1 out after reset", 32'(pwm_out), 0);
    rd(4'h0, 0, "R1 cntA reset");
    rd(4'h4, 0, "R1 cntB reset");
    rd(4'h8, 0, "R1 ctrl reset");

    // R6: high 0xFFFF, low 0 -> one tick low
    wr(4'h0, {16'hFFFF, 16'h0000});
    wr(4'h8, 32'h0000_8001);
    check(pwm_out[0] === 1'b0, "R6 one-tick low", 32'(pwm_out[0]), 0);
    @(negedge clk);
    check(pwm_out[0] === 1'b1, "R6 high after one tick", 32'(pwm_out[0]), 1);
    nh = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); nh += int'(pwm_out[0]); end
    check(nh == 100, "R6 stays high", 32'(nh), 100);

    // R7: clear enable mid-period
    wr(4'h8, 32'h0000_8000);
    check(pwm_out[0] === 1'b0, "R7 immediate stop", 32'(pwm_out[0]), 0);

    // R5: zero high count
    wr(4'h0, {16'h0000, 16'h0002});
    wr(4'h8, 32'h0000_8001);
    nh = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); nh += int'(pwm_out[0]); end
    check(nh == 0, "R5 zero high stays low", 32'(nh), 0);
    wr(4'h8, 32'h0);

    // R4 R8: low 2, high 3, prescale /3 -> 15-cycle period, 9 high
    wr(4'h0, {16'd3, 16'd2});
    wr(4'h8, 32'h0000_8201);
    nh = 0;
    for (int i = 0; i < 60; i++) begin nh += int'(pwm_out[0]); @(negedge clk); end
    check(nh == 36, "R4 R8 high cycles over 4 periods", 32'(nh), 36);

    // R9: clear gate, keep enable -> level frozen
    wr(4'h8, 32'h0000_0201);
    lvl = pwm_out[0];
    nh = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); nh += int'(pwm_out[0] !== lvl); end
    check(nh == 0, "R9 gate freeze", 32'(nh), 0);
    wr(4'h8, 32'h0);

    // R10: start at low phase, mid-period write deferred
    wr(4'h0, {16'd4, 16'd4});
    wr(4'h8, 32'h0000_8001);
    check(pwm_out[0] === 1'b0, "R10 starts low", 32'(pwm_out[0]), 0);
    wr(4'h0, {16'd1, 16'd1});
    nh = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); nh += int'(pwm_out[0]); end
    check(nh == 4, "R10 first period keeps old counts", 32'(nh), 4);
    repeat (20) @(negedge clk);
    wr(4'h8, 32'h0);
    wr(4'h8, 32'h0000_8001);
    check(pwm_out[0] === 1'b0, "R10 restart low", 32'(pwm_out[0]), 0);

    // R11 R3: channel B on source 1, prescale /2; channel A off
    wr(4'h8, 32'h0081_0042);
    wr(4'h4, {16'd2, 16'd2});
    rd(4'h0, {16'd1, 16'd1}, "R11 cntA untouched by B write");
    rd(4'h4, {16'd2, 16'd2}, "R2 cntB readback");
    repeat (60) @(negedge clk);
    wr(4'h4, {16'd5, 16'd1});
    rd(4'h0, {16'd1, 16'd1}, "R11 cntA untouched again");
    rd(4'h8, 32'h0081_0042, "R2 ctrl readback");
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, 0, "R2 unmapped reads zero");
    rd(4'h8, 32'h0081_0042, "R2 unmapped write ignored");

    // both channels on the random source, then source 3
    wr(4'h0, {16'd2, 16'd3});
    wr(4'h8, 32'h00A0_80A1 | 32'h2);
    repeat (400) @(negedge clk);
    wr(4'h8, 32'h0080_80F3);
    repeat (300) @(negedge clk);
    wr(4'h8, 32'h0);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule